// File: doc/BRIEF.md
# Predictive Shutdown Controller

This block decides whether a device should be powered down at the moment it stops working. It does not wait through an idle timeout first. It counts, in clock cycles, how long each busy interval lasts. When the busy interval ends, it compares that count with a programmable threshold. A short burst of activity is taken as a sign that a long quiet spell follows, so power-down begins in the same cycle the decision is made. A long burst is taken as a sign that more work is coming soon, so the device stays powered.

Powering down takes a programmable number of cycles, and so does powering back up. During both of those windows the device cannot serve work. A request always starts wake-up. If the request arrives while power-down is still in progress, it is held and served as soon as the device reaches the off state. A one-cycle misprediction flag fires when a request arrives within a programmable break-even window after a shutdown decision. Firmware can count these flags to retune the threshold.

Top module: `idle_predict_ctrl`

## Requirements
- R1: After a synchronous reset, `pwr_state` is 0 and `sleep_cmd`, `wake_cmd` and `mispredict` are low. The `pwr_state` encoding is: 0 = ON, 1 = SHUTTING_DOWN, 2 = OFF, 3 = WAKING.
- R2: The busy length is the number of rising clock edges at which `busy` was sampled high since it last rose. It saturates at 2^CW-1 and does not wrap. For example, with CW=8, a 300-cycle burst counts as 255.
- R3: In ON, at the first edge where `busy` is sampled low after being high, a busy length strictly less than `thresh` moves the state to SHUTTING_DOWN. `sleep_cmd` is high for exactly the first cycle of that state.
- R4: In ON, a busy length greater than or equal to `thresh` keeps the state in ON with `sleep_cmd` low. A length exactly equal to `thresh` counts as long.
- R5: SHUTTING_DOWN lasts max(`sd_delay`,1) cycles, after which the state is OFF.
- R6: In OFF, `busy` sampled high moves the state to WAKING. `wake_cmd` is high for exactly the first cycle of WAKING. WAKING lasts max(`wu_delay`,1) cycles, after which the state is ON.
- R7: `busy` sampled high during SHUTTING_DOWN does not shorten the shutdown. It is remembered, and the state goes from OFF to WAKING one cycle after OFF is reached, even if `busy` has since fallen.
- R8: Call the edge at which R3 makes its decision edge 0. A rising edge of `busy` first sampled at edge k, with 1 <= k <= `window`, produces a one-cycle `mispredict` pulse after edge k. For k > `window` there is no pulse. A `window` of 0 disables the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | Device has pending work (request) |
| thresh | input | CW | Busy-length threshold in cycles |
| sd_delay | input | DW | Shutdown duration in cycles |
| wu_delay | input | DW | Wake-up duration in cycles |
| window | input | DW | Break-even window for the misprediction flag |
| sleep_cmd | output | 1 | One-cycle power-down command |
| wake_cmd | output | 1 | One-cycle power-up command |
| pwr_state | output | 2 | Power state (encoding in R1) |
| mispredict | output | 1 | One-cycle misprediction pulse |

## Verification
The decision is driven with busy bursts that fall on either side of the threshold and exactly on it. These bursts separate a strict comparison from a non-strict one. A 300-cycle burst against a threshold of 255 separates saturation from wrap-around: a wrapped count of 44 would trigger shutdown. Requests are placed inside the shutdown window, just inside and just outside the break-even window, and in the OFF state. These placements separate the latched-request path from the direct wake path and pin the window edge to a single cycle. Zero delays confirm that each transition state still lasts at least one cycle.

// File: rtl/idle_pred_pkg.sv
package idle_pred_pkg;

    typedef enum logic [1:0] {
        ST_ON   = 2'd0,
        ST_DOWN = 2'd1,
        ST_OFF  = 2'd2,
        ST_WAKE = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } busy_edges_t;

endpackage

// File: rtl/busy_meter.sv
module busy_meter
    import idle_pred_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy,
    output busy_edges_t   edges,
    output logic [CW-1:0] len
);
    localparam logic [CW-1:0] LEN_MAX = {CW{1'b1}};

    logic busy_q;

    assign edges.rise = busy & ~busy_q;
    assign edges.fall = ~busy & busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            len    <= '0;
        end else begin
            busy_q <= busy;
            if (edges.rise)
                len <= CW'(1);
            else if (busy && len != LEN_MAX)
                len <= len + CW'(1);
        end
    end

    // R2
    len_saturate_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && busy && len == LEN_MAX) |=> len == LEN_MAX);

    // R2
    len_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && busy) |=> len >= $past(len));

endmodule

// File: rtl/power_seq.sv
module power_seq
    import idle_pred_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy,
    input  busy_edges_t   edges,
    input  logic          short_pred,
    input  logic [DW-1:0] sd_delay,
    input  logic [DW-1:0] wu_delay,
    output pwr_state_e    state,
    output logic          sleep_cmd,
    output logic          wake_cmd,
    output logic          down_start
);
    logic [DW-1:0] cnt;
    logic [DW:0]   cnt_nx;
    logic          pend;
    logic          down_done;
    logic          wake_done;

    assign cnt_nx     = {1'b0, cnt} + (DW+1)'(1);
    assign down_done  = cnt_nx >= {1'b0, sd_delay};
    assign wake_done  = cnt_nx >= {1'b0, wu_delay};
    assign down_start = (state == ST_ON) && edges.fall && short_pred;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_ON;
            cnt       <= '0;
            pend      <= 1'b0;
            sleep_cmd <= 1'b0;
            wake_cmd  <= 1'b0;
        end else begin
            sleep_cmd <= 1'b0;
            wake_cmd  <= 1'b0;
            unique case (state)
                ST_ON: begin
                    if (down_start) begin
                        state     <= ST_DOWN;
                        cnt       <= '0;
                        pend      <= 1'b0;
                        sleep_cmd <= 1'b1;
                    end
                end
                ST_DOWN: begin
                    if (busy)
                        pend <= 1'b1;
                    if (down_done)
                        state <= ST_OFF;
                    else
                        cnt <= cnt_nx[DW-1:0];
                end
                ST_OFF: begin
                    if (busy || pend) begin
                        state    <= ST_WAKE;
                        cnt      <= '0;
                        pend     <= 1'b0;
                        wake_cmd <= 1'b1;
                    end
                end
                ST_WAKE: begin
                    if (wake_done)
                        state <= ST_ON;
                    else
                        cnt <= cnt_nx[DW-1:0];
                end
                default: state <= ST_ON;
            endcase
        end
    end

    // R3
    sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_cmd |-> (state == ST_DOWN && $past(state) == ST_ON));

    // R6
    wake_entry_chk: assert property (@(posedge clk) disable iff (rst)
        wake_cmd |-> (state == ST_WAKE && $past(state) == ST_OFF));

    // R6
    off_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF) |=> (state == ST_OFF || state == ST_WAKE));

    // R4
    no_spurious_down_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ON && !edges.fall) |=> state != ST_DOWN);

    // R7
    down_no_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DOWN) |=> (state == ST_DOWN || state == ST_OFF));

endmodule

// File: rtl/miss_window.sv
module miss_window #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          rise,
    input  logic [DW-1:0] window,
    output logic          mispredict
);
    logic [DW-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt       <= '0;
            mispredict <= 1'b0;
        end else begin
            mispredict <= rise && (wcnt != '0);
            if (arm)
                wcnt <= window;
            else if (wcnt != '0)
                wcnt <= wcnt - DW'(1);
        end
    end

    // R8
    miss_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mispredict |=> !mispredict);

endmodule

// File: rtl/idle_predict_ctrl.sv
module idle_predict_ctrl
    import idle_pred_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy,
    input  logic [CW-1:0] thresh,
    input  logic [DW-1:0] sd_delay,
    input  logic [DW-1:0] wu_delay,
    input  logic [DW-1:0] window,
    output logic          sleep_cmd,
    output logic          wake_cmd,
    output logic [1:0]    pwr_state,
    output logic          mispredict
);
    busy_edges_t   edges;
    logic [CW-1:0] len;
    logic          short_pred;
    logic          down_start;
    pwr_state_e    state;

    busy_meter #(.CW(CW)) u_meter (
        .clk   (clk),
        .rst   (rst),
        .busy  (busy),
        .edges (edges),
        .len   (len)
    );

    assign short_pred = len < thresh;

    power_seq #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .edges      (edges),
        .short_pred (short_pred),
        .sd_delay   (sd_delay),
        .wu_delay   (wu_delay),
        .state      (state),
        .sleep_cmd  (sleep_cmd),
        .wake_cmd   (wake_cmd),
        .down_start (down_start)
    );

    miss_window #(.DW(DW)) u_miss (
        .clk        (clk),
        .rst        (rst),
        .arm        (down_start),
        .rise       (edges.rise),
        .window     (window),
        .mispredict (mispredict)
    );

    assign pwr_state = state;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (pwr_state == 2'd0 && !sleep_cmd && !wake_cmd && !mispredict));

endmodule

// File: tb/idle_predict_ctrl_test.sv
module idle_predict_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          busy = 1'b0;
    logic [CW-1:0] thresh = '0;
    logic [DW-1:0] sd_delay = '0;
    logic [DW-1:0] wu_delay = '0;
    logic [DW-1:0] window = '0;
    logic          sleep_cmd, wake_cmd, mispredict;
    logic [1:0]    pwr_state;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idle_predict_ctrl #(.CW(CW), .DW(DW)) uut (
        .clk(clk), .rst(rst), .busy(busy), .thresh(thresh),
        .sd_delay(sd_delay), .wu_delay(wu_delay), .window(window),
        .sleep_cmd(sleep_cmd), .wake_cmd(wake_cmd),
        .pwr_state(pwr_state), .mispredict(mispredict)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input int th, input int sd, input int wu, input int win);
        @(negedge clk);
        rst = 1'b1; busy = 1'b0;
        thresh = CW'(th); sd_delay = DW'(sd); wu_delay = DW'(wu); window = DW'(win);
        step(2);
        rst = 1'b0;
    endtask

    // burst of n sampled-high cycles, then drop; returns just after the decision edge
    task automatic burst(input int n);
        busy = 1'b1; step(n);
        busy = 1'b0; step(1);
    endtask

    task automatic t_reset();
        do_reset(10, 3, 2, 2);
        check(pwr_state, 0, "R1", "state after reset");
        check(sleep_cmd, 0, "R1", "sleep_cmd after reset");
        check(wake_cmd, 0, "R1", "wake_cmd after reset");
        check(mispredict, 0, "R1", "mispredict after reset");
    endtask

    task automatic t_short_cycle();
        do_reset(10, 3, 2, 2);
        burst(5);
        check(pwr_state, 1, "R3", "short burst enters shutdown");
        check(sleep_cmd, 1, "R3", "sleep_cmd first cycle");
        step(1);
        check(sleep_cmd, 0, "R3", "sleep_cmd one cycle only");
        check(pwr_state, 1, "R5", "still shutting down");
        step(1);
        check(pwr_state, 1, "R5", "shutdown third cycle");
        step(1);
        check(pwr_state, 2, "R5", "off after sd_delay");
        busy = 1'b1; step(1);
        check(pwr_state, 3, "R6", "request wakes");
        check(wake_cmd, 1, "R6", "wake_cmd first cycle");
        check(mispredict, 0, "R8", "request at k=4 outside window 2");
        step(1);
        check(wake_cmd, 0, "R6", "wake_cmd one cycle only");
        check(pwr_state, 3, "R6", "still waking");
        step(1);
        check(pwr_state, 0, "R6", "on after wu_delay");
        busy = 1'b0;
    endtask

    task automatic t_long_and_equal();
        do_reset(10, 3, 2, 2);
        burst(20);
        check(pwr_state, 0, "R4", "long burst stays on");
        check(sleep_cmd, 0, "R4", "no sleep_cmd on long burst");
        step(3);
        check(pwr_state, 0, "R4", "long burst stays on later");
        burst(10);
        check(pwr_state, 0, "R4", "length equal to thresh stays on");
        check(sleep_cmd, 0, "R4", "no sleep_cmd on equal length");
        burst(9);
        check(pwr_state, 1, "R3", "length thresh-1 shuts down");
    endtask

    task automatic t_pending();
        do_reset(10, 3, 2, 4);
        burst(4);
        check(pwr_state, 1, "R3", "shutdown begins");
        busy = 1'b1; step(1);
        check(pwr_state, 1, "R7", "request does not abort shutdown");
        check(mispredict, 1, "R8", "request at k=1 flags");
        busy = 1'b0; step(1);
        check(mispredict, 0, "R8", "flag lasts one cycle");
        check(pwr_state, 1, "R7", "shutdown continues");
        step(1);
        check(pwr_state, 2, "R7", "off reached");
        step(1);
        check(pwr_state, 3, "R7", "latched request wakes");
        check(wake_cmd, 1, "R7", "wake_cmd from latched request");
    endtask

    task automatic t_window_edge();
        do_reset(10, 3, 2, 4);
        burst(3);
        step(3);
        busy = 1'b1; step(1);
        check(mispredict, 1, "R8", "request at k=4 equals window");
        check(pwr_state, 3, "R6", "wake from off");
        do_reset(10, 3, 2, 4);
        burst(3);
        step(4);
        check(pwr_state, 2, "R5", "off while idle");
        busy = 1'b1; step(1);
        check(mispredict, 0, "R8", "request at k=5 past window");
        do_reset(10, 3, 2, 0);
        burst(3);
        busy = 1'b1; step(1);
        check(mispredict, 0, "R8", "window 0 disables flag");
    endtask

    task automatic t_zero_delay();
        do_reset(10, 0, 0, 0);
        burst(3);
        check(pwr_state, 1, "R5", "zero sd_delay still one cycle");
        step(1);
        check(pwr_state, 2, "R5", "off after one cycle");
        busy = 1'b1; step(1);
        check(pwr_state, 3, "R6", "zero wu_delay waking");
        step(1);
        check(pwr_state, 0, "R6", "on after one waking cycle");
        busy = 1'b0;
    endtask

    task automatic t_saturate();
        do_reset(255, 3, 2, 0);
        burst(300);
        check(pwr_state, 0, "R2", "300-cycle burst saturates, no wrap");
        do_reset(255, 3, 2, 0);
        burst(254);
        check(pwr_state, 1, "R2", "254-cycle burst below 255");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_short_cycle();
        t_long_and_equal();
        t_pending();
        t_window_edge();
        t_zero_delay();
        t_saturate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule